// File: doc/BRIEF.md
# Lockable Timer and Watchdog Register Bank

This block is the register bank that sits between a synchronous register bus and a timer and watchdog subsystem. It holds five registers. A byte-wide configuration register carries four lock bits and two mode selects. A byte-wide prescaler register carries a three-bit divider field. A 16-bit reload register holds the timer preset. A byte-wide timer control register and a byte-wide watchdog count register complete the set. The stored values drive the timer and watchdog logic directly. That logic does the counting and lies outside this block.

Each register can be sealed by a lock bit in the configuration register. Once set, a lock bit stays set until reset. A sealed register ignores writes. A read of a sealed register returns a fixed filler pattern and never the stored contents. One lock bit guards both the reload register and the timer control register. The configuration register can seal itself. The write that seals it still applies its other bits.

Top module: `tmr_regbank`

## Requirements
- R1: After synchronous active-high reset, the configuration, prescaler, timer control and watchdog count registers are 0x0000, the reload register is 0xFFFF and `rd_data` is 0x0000.
- R2: Register addresses are 0 configuration, 1 prescaler, 2 reload, 3 timer control, 4 watchdog count. On an unlocked write, the prescaler keeps `wr_data[2:0]`, the timer control and watchdog count keep `wr_data[7:0]`, and the reload keeps all 16 bits. Bits that are not kept read back as 0.
- R3: `rd_data` shows the read result on the clock edge after a cycle with `rd_en` high, and holds its value while `rd_en` is low.
- R4: A write to a locked register changes neither its output port nor its stored value.
- R5: A read of a locked register returns 0xA5A5.
- R6: Configuration bits 3:0 are lock bits. A lock bit at 1 stays 1 under any later write and returns to 0 only through reset.
- R7: Configuration bit 2 locks the reload register and the timer control register together.
- R8: Configuration bit 0 locks the configuration register. The write that sets bit 0 also applies the other bits it carries, and every later configuration write is ignored.
- R9: Configuration bit 1 locks the prescaler and bit 3 locks the watchdog count. Bit 4 drives `wd_clk_sel` and bit 5 drives `wd_svc_match`. Bits 7:6 are discarded on write and read as 0.
- R10: Addresses 5 to 7 are unmapped. A write to them changes nothing, and a read from them returns 0x0000.
- R11: When a read and a write hit the same unlocked address in one cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 16 | Write data; byte registers use the low byte |
| rd_data | output | 16 | Registered read data |
| wd_clk_sel | output | 1 | Watchdog clock source select |
| wd_svc_match | output | 1 | Watchdog service method select |
| pre_div | output | 3 | Prescaler divider field |
| reload | output | 16 | Timer reload value |
| tmr_ctl | output | 8 | Timer control/status byte |
| wd_count | output | 8 | Watchdog count byte |

## Verification
The hardest state to reach is one where only some registers are locked. No lock can be undone without a reset, so a single pass can visit only one combination. The stimulus therefore resets before each lock bit and reaches a fresh partial-lock state. It then sweeps writes and reads across every address and checks that exactly the guarded registers freeze and return filler. The self-seal case also needs its own reset. After it, the bench confirms that a write trying to set further locks was dropped.

// File: rtl/tmr_regbank_pkg.sv
`timescale 1ns/1ps
package tmr_regbank_pkg;
    localparam int DW     = 16;
    localparam int AW     = 3;
    localparam int NREG   = 5;
    localparam int NSUB   = NREG - 1;
    localparam int CFG_W  = 8;

    // configuration bit roles
    localparam int CFG_LK_SELF = 0;
    localparam int CFG_WDCLK   = 4;
    localparam int CFG_SVC     = 5;
    localparam logic [CFG_W-1:0] CFG_KEEP_MASK = 8'h3F;
    localparam logic [CFG_W-1:0] CFG_LOCK_MASK = 8'h0F;

    // subordinate registers: index i lives at address i+1
    localparam logic [DW-1:0] SUB_MASK [NSUB] = '{16'h0007, 16'hFFFF, 16'h00FF, 16'h00FF};
    localparam logic [DW-1:0] SUB_RST  [NSUB] = '{16'h0000, 16'hFFFF, 16'h0000, 16'h0000};
    localparam int            SUB_LOCK [NSUB] = '{1, 2, 2, 3};

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } cfg_st_t;

    typedef struct packed {
        logic [DW-1:0] val;
    } sub_st_t;

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_st_t;
endpackage

// File: rtl/tmr_regbank_dec.sv
`timescale 1ns/1ps
module tmr_regbank_dec
    import tmr_regbank_pkg::*;
(
    input  logic [AW-1:0]   addr,
    output logic [NREG-1:0] sel
);
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            sel[i] = (addr == AW'(i));
        end
    end
endmodule

// File: rtl/tmr_regbank_cfg.sv
`timescale 1ns/1ps
module tmr_regbank_cfg
    import tmr_regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg
);
    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && !st_q.cfg[CFG_LK_SELF]) begin
            // lock bits can only be added, never removed
            st_d.cfg = (wdata & CFG_KEEP_MASK) | (st_q.cfg & CFG_LOCK_MASK);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cfg = st_q.cfg;
endmodule

// File: rtl/tmr_regbank_lockreg.sv
`timescale 1ns/1ps
module tmr_regbank_lockreg
    import tmr_regbank_pkg::*;
#(
    parameter logic [DW-1:0] MASK    = '1,
    parameter logic [DW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          lock,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] val
);
    sub_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && !lock) begin
            st_d.val = wdata & MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.val <= RST_VAL & MASK;
        else     st_q     <= st_d;
    end

    assign val = st_q.val;
endmodule

// File: rtl/tmr_regbank.sv
`timescale 1ns/1ps
module tmr_regbank
    import tmr_regbank_pkg::*;
#(
    parameter logic [DW-1:0] LOCKED_RDATA = 16'hA5A5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [15:0]   wr_data,
    output logic [15:0]   rd_data,
    output logic          wd_clk_sel,
    output logic          wd_svc_match,
    output logic [2:0]    pre_div,
    output logic [15:0]   reload,
    output logic [7:0]    tmr_ctl,
    output logic [7:0]    wd_count
);
    logic [NREG-1:0]  sel;
    logic [CFG_W-1:0] cfg_q;
    logic [DW-1:0]    rd_val  [NREG];
    logic             rd_lock [NREG];
    rd_st_t           st_d, st_q;

    tmr_regbank_dec i_dec (
        .addr (addr),
        .sel  (sel)
    );

    tmr_regbank_cfg i_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en & sel[0]),
        .wdata (wr_data[CFG_W-1:0]),
        .cfg   (cfg_q)
    );

    assign rd_val[0]  = {{(DW-CFG_W){1'b0}}, cfg_q};
    assign rd_lock[0] = cfg_q[CFG_LK_SELF];

    for (genvar i = 0; i < NSUB; i++) begin : g_sub
        logic [DW-1:0] val;
        tmr_regbank_lockreg #(
            .MASK    (SUB_MASK[i]),
            .RST_VAL (SUB_RST[i])
        ) i_reg (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_en & sel[i+1]),
            .lock  (cfg_q[SUB_LOCK[i]]),
            .wdata (wr_data),
            .val   (val)
        );
        assign rd_val[i+1]  = val;
        assign rd_lock[i+1] = cfg_q[SUB_LOCK[i]];
    end

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.rdata = '0;
            for (int i = 0; i < NREG; i++) begin
                if (sel[i]) st_d.rdata = rd_lock[i] ? LOCKED_RDATA : rd_val[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rd_data      = st_q.rdata;
    assign wd_clk_sel   = cfg_q[CFG_WDCLK];
    assign wd_svc_match = cfg_q[CFG_SVC];
    assign pre_div      = g_sub[0].val[2:0];
    assign reload       = g_sub[1].val;
    assign tmr_ctl      = g_sub[2].val[7:0];
    assign wd_count     = g_sub[3].val[7:0];
endmodule

// File: rtl/tmr_regbank_chk.sv
`timescale 1ns/1ps
module tmr_regbank_chk #(
    parameter logic [15:0] LOCKED_RDATA = 16'hA5A5
) (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  addr,
    input logic        wr_en,
    input logic        rd_en,
    input logic [15:0] rd_data,
    input logic [3:0]  lock,
    input logic        wd_clk_sel,
    input logic        wd_svc_match,
    input logic [2:0]  pre_div,
    input logic [15:0] reload,
    input logic [7:0]  tmr_ctl,
    input logic [7:0]  wd_count
);
    // R6
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (lock != 4'b0) |=> ((lock & $past(lock)) == $past(lock)));

    // R4
    pre_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd1 && lock[1]) |=> $stable(pre_div));

    // R4
    wdc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd4 && lock[3]) |=> $stable(wd_count));

    // R7
    rld_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd2 && lock[2]) |=> $stable(reload));

    // R7
    tcs_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd3 && lock[2]) |=> $stable(tmr_ctl));

    // R5
    locked_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 3'd4 && lock[3]) |=> (rd_data == LOCKED_RDATA));

    // R8
    cfg_sealed_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd0 && lock[0]) |=>
            ($stable(lock) && $stable(wd_clk_sel) && $stable(wd_svc_match)));

    // R3
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr > 3'd4) |=> (rd_data == 16'h0000));

    // R11
    rw_same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && addr == 3'd2 && !lock[2]) |=> (rd_data == $past(reload)));
endmodule

bind tmr_regbank tmr_regbank_chk #(.LOCKED_RDATA(LOCKED_RDATA)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .addr         (addr),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .lock         (cfg_q[3:0]),
    .wd_clk_sel   (wd_clk_sel),
    .wd_svc_match (wd_svc_match),
    .pre_div      (pre_div),
    .reload       (reload),
    .tmr_ctl      (tmr_ctl),
    .wd_count     (wd_count)
);

// File: tb/test_tmr_regbank.sv
`timescale 1ns/1ps
module test_tmr_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        wd_clk_sel, wd_svc_match;
    logic [2:0]  pre_div;
    logic [15:0] reload;
    logic [7:0]  tmr_ctl, wd_count;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model of the register contents
    logic [7:0]  m_cfg;
    logic [15:0] m_val [5];

    always #4 clk = ~clk;

    tmr_regbank i_tmr_regbank (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .wd_clk_sel(wd_clk_sel),
        .wd_svc_match(wd_svc_match), .pre_div(pre_div), .reload(reload),
        .tmr_ctl(tmr_ctl), .wd_count(wd_count)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit m_locked(input int a);
        case (a)
            0:       return m_cfg[0];
            1:       return m_cfg[1];
            2, 3:    return m_cfg[2];
            4:       return m_cfg[3];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] m_read(input int a);
        if (a > 4) return 16'h0000;
        if (m_locked(a)) return 16'hA5A5;
        return m_val[a];
    endfunction

    function automatic void m_write(input int a, input logic [15:0] d);
        if (a > 4 || m_locked(a)) return;
        case (a)
            0: begin
                m_cfg    = (d[7:0] & 8'h3F) | (m_cfg & 8'h0F);
                m_val[0] = {8'h00, m_cfg};
            end
            1: m_val[1] = d & 16'h0007;
            2: m_val[2] = d;
            default: m_val[a] = d & 16'h00FF;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cfg = 8'h00;
        m_val = '{16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000};
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        addr = 3'(a); wr_data = d; wr_en = 1'b1;
        m_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a);
        logic [15:0] exp;
        exp = m_read(a);
        @(negedge clk);
        addr = 3'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, rd_data, exp);
    endtask

    task automatic out_chk(input string req);
        chk({req, " wd_clk_sel"}, {15'b0, wd_clk_sel}, {15'b0, m_cfg[4]});
        chk({req, " wd_svc_match"}, {15'b0, wd_svc_match}, {15'b0, m_cfg[5]});
        chk({req, " pre_div"}, {13'b0, pre_div}, m_val[1]);
        chk({req, " reload"}, reload, m_val[2]);
        chk({req, " tmr_ctl"}, {8'b0, tmr_ctl}, m_val[3]);
        chk({req, " wd_count"}, {8'b0, wd_count}, m_val[4]);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] pats [8];
        logic [15:0] held;
        pats = '{16'h0000, 16'hFFFF, 16'hA55A, 16'h5AA5, 16'h0001, 16'h8000, 16'h1234, 16'hFEDC};

        // R1: reset state; R10: unmapped reads
        do_reset();
        chk("R1 rd_data after reset", rd_data, 16'h0000);
        out_chk("R1");
        for (int a = 0; a < 8; a++) rd_chk(a > 4 ? "R10 unmapped read" : "R1 reset read", a);

        // R2: unlocked write/readback with field masks
        for (int p = 0; p < 8; p++) begin
            for (int a = 1; a < 5; a++) begin
                wr(a, pats[p]);
                rd_chk("R2 readback", a);
            end
            out_chk("R2");
        end

        // R9: mode bits of the configuration register, lock bits kept clear
        for (int v = 0; v < 4; v++) begin
            wr(0, 16'h00C0 | 16'(v << 4));
            rd_chk("R9 cfg readback", 0);
            out_chk("R9");
        end

        // R10: writes to unmapped addresses leave every register unchanged
        for (int a = 5; a < 8; a++) wr(a, 16'hFFFF);
        for (int a = 0; a < 5; a++) rd_chk("R10 unmapped write", a);
        out_chk("R10");

        // R3: rd_data holds while rd_en is low
        wr(2, 16'h4321);
        rd_chk("R3 read", 2);
        held = rd_data;
        wr(2, 16'h9999);
        @(negedge clk); addr = 3'd7;
        @(negedge clk);
        chk("R3 hold", rd_data, held);

        // R11: read and write in the same cycle return the old value
        begin
            logic [15:0] old;
            old = m_read(2);
            @(negedge clk);
            addr = 3'd2; wr_data = 16'h0BAD; wr_en = 1'b1; rd_en = 1'b1;
            m_write(2, 16'h0BAD);
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
            chk("R11 old value", rd_data, old);
            chk("R11 new stored", reload, 16'h0BAD);
        end

        // R4 R5 R6 R7 R9: one lock bit at a time, sweep all registers
        for (int k = 1; k < 4; k++) begin
            do_reset();
            for (int a = 1; a < 5; a++) wr(a, 16'h1111 * 16'(a));
            wr(0, 16'(1 << k));
            for (int a = 1; a < 5; a++) begin
                wr(a, 16'hC3C3);
                rd_chk(m_locked(a) ? "R5 locked read" : "R4 neighbour unlocked", a);
            end
            out_chk(k == 2 ? "R7" : "R4");
            wr(0, 16'h0000);
            rd_chk("R6 lock sticky", 0);
            for (int a = 1; a < 5; a++) wr(a, 16'h0F0F);
            out_chk("R6 still locked");
        end

        // R8: self-seal applies its own mode bits, later writes dropped
        do_reset();
        wr(0, 16'h0031);
        out_chk("R8 same write");
        rd_chk("R8 sealed read", 0);
        wr(0, 16'h000E);
        wr(1, 16'h0005);
        rd_chk("R8 later lock dropped", 1);
        out_chk("R8");

        // R6: reset clears every lock
        do_reset();
        rd_chk("R6 reset clears", 0);
        wr(4, 16'h00AB);
        rd_chk("R6 writable after reset", 4);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule